// File: doc/BRIEF.md
# CAN Bit Timing Segment Sequencer

This block splits every nominal bit on a CAN line into time quanta. Each bit has four segments: one sync quantum, then a propagation segment, then phase segment 1, then phase segment 2. A time-quantum tick from an external prescaler advances the sequence by one quantum. The block raises a sample strobe at the end of phase segment 1 and keeps the sampled line value. It raises a bit-start strobe whenever a new bit begins. Frame logic downstream uses these strobes.

Falling (recessive-to-dominant) edges on the received line move the bit grid to follow the transmitter:

- A late edge lengthens phase segment 1.
- An early edge shortens phase segment 2.
- Each adjustment is limited by a programmable jump width.
- At most one adjustment is made between two sample points.
- While the bus is idle, a hard-sync enable lets a start-of-frame edge restart the bit outright.

A configuration checker flags illegal segment settings. While the flag is raised, the sequencer is held at the start of a bit.

Top module: `can_bit_sequencer`

## Requirements
- R1: With no adjustment, the sample pulse rises on the tick that ends quantum 1+P+A of the bit, where P is the propagation length and A is the phase-1 length. The reference case P=2, A=7, B=6 samples on tick 10. `sample_bit` takes the line value at that tick and changes at no other time.
- R2: The bit-start pulse rises on the tick that ends phase segment 2. The next tick then closes the sync quantum of the new bit, so an unadjusted bit lasts 1+P+A+B quanta. The bit-start pulse and the sample pulse never rise together.
- R3: Suppose a falling edge is seen at a tick that ends quantum k after the sync quantum, and that quantum lies in the propagation segment or phase segment 1. Phase segment 1 then grows by min(k, J) quanta, where J is the jump width.
- R4: Suppose a falling edge is seen at the tick that ends quantum c of phase segment 2. Phase segment 2 then shrinks by min(B−c, J) quanta.
- R5: A falling edge seen at the tick that ends the sync quantum causes no adjustment. Rising edges never cause one.
- R6: After one adjustment, further edges are ignored until the next sample pulse.
- R7: While `idle_sync_en` is 1, a falling edge restarts the bit. The pulse `bit_start` rises for that tick, and that quantum counts as the sync quantum. The sample then falls P+A ticks later, and no adjustment takes place in that bit.
- R8: The jump width is J = `sjw_code` + 1, so codes 0 to 3 give 1 to 4 quanta.
- R9: `cfg_bad` is 1, without delay, when any of these holds: P = 0, A = 0, P+A < B, or B ≤ J. It is 0 otherwise.
- R10: While `cfg_bad` is 1, no pulses are produced and the sequencer sits at the start of a bit. Once the flag clears, the first sample falls on tick 1+P+A.
- R11: After reset, both pulses are 0 and `sample_bit` is 1 (recessive).
- R12: The pulses are registered. Each lasts one clock and appears in the clock after the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_tick | input | 1 | One-clock pulse marking the end of a time quantum |
| rx_bit | input | 1 | Received line value, 1 = recessive |
| idle_sync_en | input | 1 | Bus idle: the next falling edge is a hard sync |
| seg_prop | input | SEG_W | Propagation segment length in quanta |
| seg_ph1 | input | SEG_W | Phase segment 1 length in quanta |
| seg_ph2 | input | SEG_W | Phase segment 2 length in quanta |
| sjw_code | input | 2 | Jump width code, width = code + 1 |
| sample_pulse | output | 1 | One-clock strobe at the sample point |
| sample_bit | output | 1 | Line value captured at the last sample point |
| bit_start | output | 1 | One-clock strobe at the start of each bit |
| cfg_bad | output | 1 | Segment configuration is illegal |

## Verification
The bench first drives a constant recessive line and a line that toggles exactly at bit boundaries. These show the unadjusted grid and show that edges in the sync quantum and rising edges move nothing.

Single falling edges are then placed in the propagation segment, in phase segment 1 and in phase segment 2, under several jump-width codes. Some placements make the clamp decide the shift and some make the edge error decide it. This separates lengthening from shortening, and the encoded width from the raw code. A second edge placed right after an early adjustment shows the one-adjustment lock.

Edges with the idle enable set show the hard restart. Legal, boundary and illegal configurations, together with a release from the illegal state, cover the checker and the hold.

// File: rtl/btq_pkg.sv
package btq_pkg;
   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PROP = 2'd1,
      SEG_PH1  = 2'd2,
      SEG_PH2  = 2'd3
   } seg_e;

   localparam int unsigned SJW_CODE_W = 2;
   localparam int unsigned SJW_W      = 3;
endpackage

// File: rtl/btq_cfg_check.sv
module btq_cfg_check
   import btq_pkg::*;
#(
   parameter int unsigned SEG_W = 4
) (
   input  logic [SEG_W-1:0]      prop,
   input  logic [SEG_W-1:0]      ph1,
   input  logic [SEG_W-1:0]      ph2,
   input  logic [SJW_CODE_W-1:0] sjw_code,
   output logic [SJW_W-1:0]      sjw,
   output logic                  bad
);
   localparam int unsigned SUM_W = SEG_W + 1;

   logic [SUM_W-1:0] early_sum;
   logic             zero_len;
   logic             sum_short;
   logic             ph2_small;

   always_comb begin
      sjw       = {1'b0, sjw_code} + SJW_W'(1);
      early_sum = SUM_W'(prop) + SUM_W'(ph1);
      zero_len  = (prop == '0) || (ph1 == '0);
      sum_short = early_sum < SUM_W'(ph2);
      ph2_small = SUM_W'(ph2) <= SUM_W'(sjw);
      bad       = zero_len || sum_short || ph2_small;
   end
endmodule

// File: rtl/btq_edge_det.sv
module btq_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic tq_tick,
   input  logic rx,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       prev_q <= 1'b1;
      else if (tq_tick) prev_q <= rx;
   end

   assign fall = tq_tick && prev_q && !rx;
endmodule

// File: rtl/btq_seq_core.sv
module btq_seq_core
   import btq_pkg::*;
#(
   parameter int unsigned SEG_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tq_tick,
   input  logic              rx,
   input  logic              fall,
   input  logic              hs_en,
   input  logic              cfg_bad,
   input  logic [SEG_W-1:0]  prop,
   input  logic [SEG_W-1:0]  ph1,
   input  logic [SEG_W-1:0]  ph2,
   input  logic [SJW_W-1:0]  sjw,
   output logic              sample_pulse,
   output logic              sample_bit,
   output logic              bit_start
);
   localparam int unsigned ERR_W = SEG_W + 2;

   seg_e             seg_q;
   logic [ERR_W-1:0] cnt_q;
   logic [SJW_W-1:0] add_q, sub_q;
   logic             rs_done_q;
   logic             sp_q, bs_q, sb_q;

   logic [ERR_W-1:0] prop_w, ph1_w, ph2_w;
   logic [ERR_W-1:0] late_err, early_err;
   logic [ERR_W-1:0] ph1_end, ph2_end;
   logic [SJW_W-1:0] add_cur, sub_cur;
   logic             hard, rs_ok, late_rs, early_rs;

   function automatic logic [SJW_W-1:0] clamp_fn(input logic [ERR_W-1:0] e,
                                                 input logic [SJW_W-1:0] lim);
      if (e < ERR_W'(lim)) return e[SJW_W-1:0];
      return lim;
   endfunction

   always_comb begin
      prop_w    = ERR_W'(prop);
      ph1_w     = ERR_W'(ph1);
      ph2_w     = ERR_W'(ph2);
      hard      = fall && hs_en;
      rs_ok     = fall && !hs_en && !rs_done_q;
      late_rs   = rs_ok && ((seg_q == SEG_PROP) || (seg_q == SEG_PH1));
      early_rs  = rs_ok && (seg_q == SEG_PH2);
      late_err  = (seg_q == SEG_PROP) ? cnt_q : prop_w + cnt_q;
      early_err = (cnt_q < ph2_w) ? ph2_w - cnt_q : '0;
      add_cur   = late_rs  ? clamp_fn(late_err, sjw)  : add_q;
      sub_cur   = early_rs ? clamp_fn(early_err, sjw) : sub_q;
      ph1_end   = ph1_w + ERR_W'(add_cur);
      ph2_end   = ph2_w - ERR_W'(sub_cur);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || cfg_bad) begin
         seg_q     <= SEG_SYNC;
         cnt_q     <= '0;
         add_q     <= '0;
         sub_q     <= '0;
         rs_done_q <= 1'b0;
         sp_q      <= 1'b0;
         bs_q      <= 1'b0;
         sb_q      <= 1'b1;
      end else begin
         sp_q <= 1'b0;
         bs_q <= 1'b0;
         if (tq_tick) begin
            if (hard) begin
               seg_q     <= SEG_PROP;
               cnt_q     <= ERR_W'(1);
               add_q     <= '0;
               sub_q     <= '0;
               rs_done_q <= 1'b1;
               bs_q      <= 1'b1;
            end else begin
               unique case (seg_q)
                  SEG_SYNC: begin
                     seg_q <= SEG_PROP;
                     cnt_q <= ERR_W'(1);
                  end
                  SEG_PROP: begin
                     add_q <= add_cur;
                     if (late_rs) rs_done_q <= 1'b1;
                     if (cnt_q >= prop_w) begin
                        seg_q <= SEG_PH1;
                        cnt_q <= ERR_W'(1);
                     end else begin
                        cnt_q <= cnt_q + ERR_W'(1);
                     end
                  end
                  SEG_PH1: begin
                     add_q <= add_cur;
                     if (cnt_q >= ph1_end) begin
                        seg_q     <= SEG_PH2;
                        cnt_q     <= ERR_W'(1);
                        sp_q      <= 1'b1;
                        sb_q      <= rx;
                        rs_done_q <= 1'b0;
                     end else begin
                        cnt_q <= cnt_q + ERR_W'(1);
                        if (late_rs) rs_done_q <= 1'b1;
                     end
                  end
                  default: begin
                     sub_q <= sub_cur;
                     if (early_rs) rs_done_q <= 1'b1;
                     if (cnt_q >= ph2_end) begin
                        seg_q <= SEG_SYNC;
                        cnt_q <= '0;
                        add_q <= '0;
                        sub_q <= '0;
                        bs_q  <= 1'b1;
                     end else begin
                        cnt_q <= cnt_q + ERR_W'(1);
                     end
                  end
               endcase
            end
         end
      end
   end

   assign sample_pulse = sp_q;
   assign bit_start    = bs_q;
   assign sample_bit   = sb_q;

   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(sp_q && bs_q)); // R2
   AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_q || bs_q) |-> $past(tq_tick)); // R12
   AST_HOLD_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_bad |=> (!sp_q && !bs_q)); // R10
   AST_BIT_ONLY_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sb_q) && !$past(cfg_bad)) |-> sp_q); // R1
   AST_ADD_WITHIN_JUMP: assert property (@(posedge clk) disable iff (!rst_n || cfg_bad)
      add_q <= sjw); // R3
   AST_SUB_WITHIN_JUMP: assert property (@(posedge clk) disable iff (!rst_n || cfg_bad)
      sub_q <= sjw); // R4
endmodule

// File: rtl/can_bit_sequencer.sv
module can_bit_sequencer
   import btq_pkg::*;
#(
   parameter int unsigned SEG_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tq_tick,
   input  logic                  rx_bit,
   input  logic                  idle_sync_en,
   input  logic [SEG_W-1:0]      seg_prop,
   input  logic [SEG_W-1:0]      seg_ph1,
   input  logic [SEG_W-1:0]      seg_ph2,
   input  logic [SJW_CODE_W-1:0] sjw_code,
   output logic                  sample_pulse,
   output logic                  sample_bit,
   output logic                  bit_start,
   output logic                  cfg_bad
);
   if (SEG_W < 3 || SEG_W > 8) begin : g_bad_seg_w
      $error("can_bit_sequencer: SEG_W must lie in 3..8");
   end

   logic [SJW_W-1:0] sjw;
   logic             fall;

   btq_cfg_check #(.SEG_W(SEG_W)) u_cfg (
      .prop     (seg_prop),
      .ph1      (seg_ph1),
      .ph2      (seg_ph2),
      .sjw_code (sjw_code),
      .sjw      (sjw),
      .bad      (cfg_bad)
   );

   btq_edge_det u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .tq_tick (tq_tick),
      .rx      (rx_bit),
      .fall    (fall)
   );

   btq_seq_core #(.SEG_W(SEG_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .tq_tick      (tq_tick),
      .rx           (rx_bit),
      .fall         (fall),
      .hs_en        (idle_sync_en),
      .cfg_bad      (cfg_bad),
      .prop         (seg_prop),
      .ph1          (seg_ph1),
      .ph2          (seg_ph2),
      .sjw          (sjw),
      .sample_pulse (sample_pulse),
      .sample_bit   (sample_bit),
      .bit_start    (bit_start)
   );
endmodule

// File: tb/can_bit_sequencer_bench.sv
module can_bit_sequencer_bench;
   localparam int SEG_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tq_tick = 1'b0;
   logic             rx_bit = 1'b1;
   logic             idle_sync_en = 1'b0;
   logic [SEG_W-1:0] seg_prop = 4'd2;
   logic [SEG_W-1:0] seg_ph1 = 4'd7;
   logic [SEG_W-1:0] seg_ph2 = 4'd6;
   logic [1:0]       sjw_code = 2'd0;
   logic             sample_pulse, sample_bit, bit_start, cfg_bad;

   int checks = 0;
   int fails  = 0;
   int ns, nb;
   int s_at [4];
   int b_at [4];
   logic sb_at [4];

   always #10 clk = ~clk;

   can_bit_sequencer #(.SEG_W(SEG_W)) u_can_bit_sequencer (
      .clk (clk), .rst_n (rst_n), .tq_tick (tq_tick), .rx_bit (rx_bit),
      .idle_sync_en (idle_sync_en), .seg_prop (seg_prop), .seg_ph1 (seg_ph1),
      .seg_ph2 (seg_ph2), .sjw_code (sjw_code), .sample_pulse (sample_pulse),
      .sample_bit (sample_bit), .bit_start (bit_start), .cfg_bad (cfg_bad)
   );

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic set_cfg(input int p, input int a, input int b, input int j);
      seg_prop = SEG_W'(p);
      seg_ph1  = SEG_W'(a);
      seg_ph2  = SEG_W'(b);
      sjw_code = 2'(j);
   endtask

   task automatic restart(input int p, input int a, input int b, input int j);
      @(negedge clk);
      rst_n = 1'b0; tq_tick = 1'b0; rx_bit = 1'b1; idle_sync_en = 1'b0;
      set_cfg(p, a, b, j);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // rx is 0 for a1 <= t < b1 and for t >= a2 (a2 = 0: unused), else 1
   task automatic run_seq(input int n, input int a1, input int b1, input int a2,
                          input logic hs);
      ns = 0; nb = 0;
      for (int i = 0; i < 4; i++) begin s_at[i] = -1; b_at[i] = -1; sb_at[i] = 1'b1; end
      for (int t = 1; t <= n; t++) begin
         rx_bit = !((t >= a1 && t < b1) || (a2 != 0 && t >= a2));
         idle_sync_en = hs;
         tq_tick = 1'b1;
         @(negedge clk);
         tq_tick = 1'b0;
         if (sample_pulse) begin
            if (ns < 4) begin s_at[ns] = t; sb_at[ns] = sample_bit; end
            ns++;
         end
         if (bit_start) begin
            if (nb < 4) b_at[nb] = t;
            nb++;
         end
         @(negedge clk);
      end
      idle_sync_en = 1'b0;
   endtask

   task automatic t_reset();
      restart(2, 7, 6, 0);
      check("R11 sample_pulse after reset", int'(sample_pulse), 0);
      check("R11 bit_start after reset", int'(bit_start), 0);
      check("R11 sample_bit after reset", int'(sample_bit), 1);
      check("R9 legal reference cfg", int'(cfg_bad), 0);
   endtask

   task automatic t_nominal();
      restart(2, 7, 6, 0);
      run_seq(45, 17, 33, 0, 1'b0);
      check("R1 first sample tick", s_at[0], 10);
      check("R1 first sample value", int'(sb_at[0]), 1);
      check("R2 first bit start tick", b_at[0], 16);
      check("R5 sample after sync-quantum edge", s_at[1], 26);
      check("R1 second sample value", int'(sb_at[1]), 0);
      check("R2 second bit start tick", b_at[1], 32);
      check("R5 sample after rising edge", s_at[2], 42);
      check("R1 third sample value", int'(sb_at[2]), 1);
   endtask

   task automatic t_late();
      restart(2, 7, 6, 0);
      run_seq(20, 3, 100, 0, 1'b0);
      check("R3 prop edge clamped to 1", s_at[0], 11);
      check("R3 sampled dominant", int'(sb_at[0]), 0);
      check("R3 bit start after lengthened bit", b_at[0], 17);
      restart(2, 7, 6, 3);
      run_seq(22, 5, 100, 0, 1'b0);
      check("R8 ph1 edge, code 3 width 4", s_at[0], 14);
      check("R3 bit start after +4", b_at[0], 20);
   endtask

   task automatic t_early();
      restart(2, 7, 6, 0);
      run_seq(28, 12, 100, 0, 1'b0);
      check("R4 sample before early edge", s_at[0], 10);
      check("R4 ph2 shortened by 1", b_at[0], 15);
      check("R4 next sample", s_at[1], 25);
      restart(2, 7, 6, 1);
      run_seq(28, 12, 100, 0, 1'b0);
      check("R8 code 1 shortens by 2", b_at[0], 14);
      check("R4 next sample after -2", s_at[1], 24);
   endtask

   task automatic t_one_resync();
      restart(2, 7, 6, 0);
      run_seq(28, 12, 16, 17, 1'b0);
      check("R6 first adjustment", b_at[0], 15);
      check("R6 second edge ignored", s_at[1], 25);
   endtask

   task automatic t_hard();
      restart(2, 7, 6, 3);
      run_seq(22, 5, 100, 0, 1'b1);
      check("R7 bit start on hard edge", b_at[0], 5);
      check("R7 sample after hard sync", s_at[0], 14);
      check("R7 following bit start", b_at[1], 20);
   endtask

   task automatic t_cfg();
      restart(1, 3, 5, 0);
      check("R9 prop+ph1 below ph2", int'(cfg_bad), 1);
      restart(2, 7, 2, 1);
      check("R9 ph2 equal to width", int'(cfg_bad), 1);
      restart(0, 7, 3, 0);
      check("R9 zero prop", int'(cfg_bad), 1);
      restart(2, 0, 2, 0);
      check("R9 zero ph1", int'(cfg_bad), 1);
      restart(1, 2, 3, 1);
      check("R9 boundary legal", int'(cfg_bad), 0);
      run_seq(10, 0, 0, 0, 1'b0);
      check("R1 boundary sample tick", s_at[0], 4);
      check("R2 boundary bit start", b_at[0], 7);
   endtask

   task automatic t_hold();
      restart(1, 3, 5, 0);
      run_seq(30, 0, 0, 0, 1'b0);
      check("R10 no samples while illegal", ns, 0);
      check("R10 no bit starts while illegal", nb, 0);
      set_cfg(2, 7, 6, 0);
      @(negedge clk);
      check("R9 flag clears", int'(cfg_bad), 0);
      run_seq(12, 0, 0, 0, 1'b0);
      check("R10 restart from sync", s_at[0], 10);
   endtask

   logic done = 1'b0;

   initial begin
      t_reset();
      t_nominal();
      t_late();
      t_early();
      t_one_resync();
      t_hard();
      t_cfg();
      t_hold();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule